// File: doc/BRIEF.md
# Strap-Selected RMII Pin Multiplexer

This block owns a bank of multi-function pads and two management pads. It captures two strap inputs on every clock edge while the synchronous active-low reset is held, and the values it holds when reset is released fix the pad usage until the next reset. The possible uses are general-purpose I/O, an RMII link with the internal MAC acting as the MAC, or a reverse RMII link in which the chip poses as a PHY toward an external MAC.

In both RMII uses the physical pad directions are the same: pads 2, 3 and 4 carry the internal MAC's transmit enable and dibit outward, and pads 1, 6 and 7 carry the far end's signals inward. The modes differ in what the wires are called at the board level and in the management clock pad. That pad drives in MAC mode and listens in reverse mode. Pad 0 is always a GPIO, and the direction of pad 5, the 50 MHz reference clock, comes from a separate static flag. In GPIO mode, per-bit direction and data registers control every pad. The management pads then show two indicator signals, and the MAC inputs are held idle.

Top module: `pinmux_rmii_top`

## Requirements
- R1: While rst_n is 0, the straps are captured on every rising clock edge. After release, `mode_status` keeps the captured value and later strap changes have no effect. Encoding: 2'b10 GPIO when `strap_sel_gpio`=1 (whatever `strap_mac_side` is), 2'b01 MAC side when the straps are 0/1, and 2'b00 reverse side when both are 0.
- R2: While rst_n is 0, and until the first rising edge that samples rst_n high, every pad output enable (`mfp_oe`, `mdc_pad_oe`, `mdio_pad_oe`) is 0.
- R3: In GPIO mode `mfp_oe` equals the direction register and the driven `mfp_out` bits equal the data register. `gpio_rdata` always equals `mfp_in`.
- R4: `gpio_we_dir` / `gpio_we_dat` load `gpio_wdata` into the direction / data register at the next rising edge. Both registers clear to 0 in reset, and a write while rst_n is 0 is lost.
- R5: MAC mode: pad2=`mac_tx_en`, pad3=`mac_txd[1]`, pad4=`mac_txd[0]`, all enabled. `mac_crs_dv`=pad1, `mac_rxd[1]`=pad6, `mac_rxd[0]`=pad7, and these three pads are not enabled.
- R6: Reverse mode uses the same pad positions and directions. Pad1 brings the far MAC's transmit enable into `mac_crs_dv`, pads 6/7 bring its dibit into `mac_rxd`, and pads 2/3/4 present `mac_tx_en`/`mac_txd` as carrier-sense and receive data.
- R7: Pad 0 follows the GPIO direction and data registers in every mode. GPIO register bits for pads taken by RMII have no effect there.
- R8: In the RMII modes, with `ref_clk_drive`=1, pad5 is enabled and driven with `ref_clk_gen`. With 0, pad5 is an input and `mac_ref_clk`=`mfp_in[5]`. In GPIO mode `mac_ref_clk`=`ref_clk_gen`.
- R9: The management clock pad is enabled and driven with `mac_mdc_o` in MAC mode. In reverse mode it is not enabled and `mac_mdc_i`=`mdc_pad_in`. Otherwise `mac_mdc_i`=0.
- R10: In both RMII modes the management data pad drives `mac_mdio_o` under `mac_mdio_oe`, and `mac_mdio_i`=`mdio_pad_in`.
- R11: In GPIO mode the management pads are enabled and driven with `ind_mdc`/`ind_mdio`. The MAC inputs sit idle: `mac_crs_dv`=0, `mac_rxd`=0, `mac_mdio_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| strap_sel_gpio | input | 1 | Strap: 1 selects GPIO use |
| strap_mac_side | input | 1 | Strap: 1 MAC side, 0 reverse side |
| ref_clk_drive | input | 1 | Static flag: 1 drives the reference clock pad |
| ref_clk_gen | input | 1 | Internally generated reference clock |
| gpio_we_dir | input | 1 | Direction register write strobe |
| gpio_we_dat | input | 1 | Data register write strobe |
| gpio_wdata | input | 8 | Write data for the GPIO registers |
| gpio_rdata | output | 8 | Pad input levels |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_txd | input | 2 | MAC transmit dibit |
| mac_crs_dv | output | 1 | To MAC: carrier sense / data valid |
| mac_rxd | output | 2 | To MAC: receive dibit |
| mac_ref_clk | output | 1 | To MAC: reference clock |
| mac_mdc_o | input | 1 | Management clock from the MAC side |
| mac_mdc_i | output | 1 | Management clock received in reverse mode |
| mac_mdio_o | input | 1 | Management data out |
| mac_mdio_oe | input | 1 | Management data drive enable |
| mac_mdio_i | output | 1 | Management data in |
| ind_mdc | input | 1 | Indicator level for the clock pad in GPIO mode |
| ind_mdio | input | 1 | Indicator level for the data pad in GPIO mode |
| mfp_in | input | 8 | Multi-function pad inputs |
| mfp_out | output | 8 | Multi-function pad outputs |
| mfp_oe | output | 8 | Multi-function pad output enables |
| mdc_pad_in | input | 1 | Management clock pad input |
| mdc_pad_out | output | 1 | Management clock pad output |
| mdc_pad_oe | output | 1 | Management clock pad enable |
| mdio_pad_in | input | 1 | Management data pad input |
| mdio_pad_out | output | 1 | Management data pad output |
| mdio_pad_oe | output | 1 | Management data pad enable |
| mode_status | output | 2 | Captured mode |

## Verification
A GPIO register write can fall on the same rising edge that first samples reset released, which is also the edge that ends the tri-state hold. The bench provokes this by writing during a reset cycle, a write that must be lost. It then raises rst_n and a direction write together before one edge. On the following negative edge it expects the second value already on `mfp_oe`, with no intermediate all-zero-then-update cycle. A separate check changes the straps after release in the same cycle as pad traffic, and the pads must keep the captured mode.

// File: rtl/pinmux_pkg.sv
// Shared types and pad positions for the strap-selected pin multiplexer.
// Assumes the RMII bank occupies pads 1..7 of the multi-function bank.
package pinmux_pkg;
    typedef enum logic [1:0] {
        MODE_REV  = 2'b00,
        MODE_MAC  = 2'b01,
        MODE_GPIO = 2'b10
    } pin_mode_e;

    // Pad positions are fixed by board wiring, not free choices.
    localparam int PAD_GP0   = 0;
    localparam int PAD_DVIN  = 1;
    localparam int PAD_ENOUT = 2;
    localparam int PAD_D1OUT = 3;
    localparam int PAD_D0OUT = 4;
    localparam int PAD_REF   = 5;
    localparam int PAD_D1IN  = 6;
    localparam int PAD_D0IN  = 7;
    localparam int RMII_PADS = 8;

    // Map raw straps to a mode: GPIO strap dominates.
    function automatic pin_mode_e strap_decode(input logic sel_gpio, input logic mac_side);
        if (sel_gpio)      return MODE_GPIO;
        else if (mac_side) return MODE_MAC;
        else               return MODE_REV;
    endfunction
endpackage

// File: rtl/pm_strap_latch.sv
// Strap capture: samples the straps on each edge while rst_n is low,
// holds them afterwards, and raises live one edge after release.
// Assumes straps are stable around the releasing edge.
module pm_strap_latch
    import pinmux_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strap_sel_gpio,
    input  logic      strap_mac_side,
    output pin_mode_e mode_q,
    output logic      live_q
);
    // Capture straps during reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= strap_decode(strap_sel_gpio, strap_mac_side);
    end

    // Pads stay released until the first edge with reset high.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> $stable(mode_q)); // R1
    AST_LIVE_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !live_q); // R2
endmodule

// File: rtl/pm_gpio_regs.sv
// GPIO direction and data registers with separate write strobes.
// Assumes synchronous active-low reset clears both registers.
module pm_gpio_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_dir,
    input  logic         we_dat,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] dat_q
);
    // Direction register.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (we_dir) dir_q <= wdata;
    end

    // Data register.
    always_ff @(posedge clk) begin
        if (!rst_n)      dat_q <= '0;
        else if (we_dat) dat_q <= wdata;
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we_dir |=> dir_q == $past(wdata)); // R4
    AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_dat |=> $stable(dat_q)); // R4
endmodule

// File: rtl/pm_pad_route.sv
// Pad routing: chooses per-pad drive and enable from the captured mode,
// routes pad inputs to the MAC port and forces idle levels when unused.
// Assumes W >= RMII_PADS; pads above the RMII bank are always GPIO.
module pm_pad_route
    import pinmux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pin_mode_e    mode,
    input  logic         live,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] dat,
    input  logic         ref_clk_drive,
    input  logic         ref_clk_gen,
    input  logic         mac_tx_en,
    input  logic [1:0]   mac_txd,
    output logic         mac_crs_dv,
    output logic [1:0]   mac_rxd,
    output logic         mac_ref_clk,
    input  logic         mac_mdc_o,
    output logic         mac_mdc_i,
    input  logic         mac_mdio_o,
    input  logic         mac_mdio_oe,
    output logic         mac_mdio_i,
    input  logic         ind_mdc,
    input  logic         ind_mdio,
    input  logic [W-1:0] mfp_in,
    output logic [W-1:0] mfp_out,
    output logic [W-1:0] mfp_oe,
    input  logic         mdc_pad_in,
    output logic         mdc_pad_out,
    output logic         mdc_pad_oe,
    input  logic         mdio_pad_in,
    output logic         mdio_pad_out,
    output logic         mdio_pad_oe
);
    logic rmii_on;
    logic [RMII_PADS-1:0] r_out;
    logic [RMII_PADS-1:0] r_oe;
    logic [RMII_PADS-1:0] r_own;

    // Whether a link mode owns the RMII pads.
    assign rmii_on = (mode == MODE_MAC) || (mode == MODE_REV);

    // RMII-side drive, enable and ownership of each bank pad.
    always_comb begin
        r_out = '0;
        r_oe  = '0;
        r_own = '0;
        r_own[PAD_DVIN]  = 1'b1;
        r_own[PAD_ENOUT] = 1'b1;
        r_own[PAD_D1OUT] = 1'b1;
        r_own[PAD_D0OUT] = 1'b1;
        r_own[PAD_REF]   = 1'b1;
        r_own[PAD_D1IN]  = 1'b1;
        r_own[PAD_D0IN]  = 1'b1;
        r_out[PAD_ENOUT] = mac_tx_en;
        r_out[PAD_D1OUT] = mac_txd[1];
        r_out[PAD_D0OUT] = mac_txd[0];
        r_out[PAD_REF]   = ref_clk_gen;
        r_oe[PAD_ENOUT]  = 1'b1;
        r_oe[PAD_D1OUT]  = 1'b1;
        r_oe[PAD_D0OUT]  = 1'b1;
        r_oe[PAD_REF]    = ref_clk_drive;
    end

    // Per-pad selection between GPIO registers and RMII function.
    for (genvar i = 0; i < W; i++) begin : g_pad
        if (i < RMII_PADS) begin : g_bank
            assign mfp_out[i] = (rmii_on && r_own[i]) ? r_out[i] : dat[i];
            assign mfp_oe[i]  = live & ((rmii_on && r_own[i]) ? r_oe[i] : dir[i]);
        end else begin : g_extra
            assign mfp_out[i] = dat[i];
            assign mfp_oe[i]  = live & dir[i];
        end
    end

    // Inputs toward the MAC, idle outside link modes or before release.
    always_comb begin
        if (rmii_on && live) begin
            mac_crs_dv = mfp_in[PAD_DVIN];
            mac_rxd    = {mfp_in[PAD_D1IN], mfp_in[PAD_D0IN]};
            mac_mdio_i = mdio_pad_in;
        end else begin
            mac_crs_dv = 1'b0;
            mac_rxd    = 2'b00;
            mac_mdio_i = 1'b1;
        end
        mac_ref_clk = (rmii_on && !ref_clk_drive) ? mfp_in[PAD_REF] : ref_clk_gen;
        mac_mdc_i   = (mode == MODE_REV && live) ? mdc_pad_in : 1'b0;
    end

    // Management pads per mode.
    always_comb begin
        unique case (mode)
            MODE_MAC: begin
                mdc_pad_out = mac_mdc_o;   mdc_pad_oe  = live;
                mdio_pad_out = mac_mdio_o; mdio_pad_oe = live & mac_mdio_oe;
            end
            MODE_REV: begin
                mdc_pad_out = 1'b0;        mdc_pad_oe  = 1'b0;
                mdio_pad_out = mac_mdio_o; mdio_pad_oe = live & mac_mdio_oe;
            end
            default: begin
                mdc_pad_out = ind_mdc;     mdc_pad_oe  = live;
                mdio_pad_out = ind_mdio;   mdio_pad_oe = live;
            end
        endcase
    end

    AST_TRISTATE_RESET: assert property (@(posedge clk)
        !live |-> (mfp_oe == '0) && !mdc_pad_oe && !mdio_pad_oe); // R2
    AST_REV_MDC_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REV) |-> !mdc_pad_oe); // R9
    AST_GPIO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_GPIO) |-> !mac_crs_dv && (mac_rxd == 2'b00) && mac_mdio_i); // R11
    AST_PIN0_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (mfp_oe[PAD_GP0] == dir[PAD_GP0])); // R7
endmodule

// File: rtl/pinmux_rmii_top.sv
// Top of the strap-selected pin multiplexer: strap capture, GPIO
// registers and pad routing. Assumes an eight-pad multi-function bank.
module pinmux_rmii_top
    import pinmux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_sel_gpio,
    input  logic         strap_mac_side,
    input  logic         ref_clk_drive,
    input  logic         ref_clk_gen,
    input  logic         gpio_we_dir,
    input  logic         gpio_we_dat,
    input  logic [W-1:0] gpio_wdata,
    output logic [W-1:0] gpio_rdata,
    input  logic         mac_tx_en,
    input  logic [1:0]   mac_txd,
    output logic         mac_crs_dv,
    output logic [1:0]   mac_rxd,
    output logic         mac_ref_clk,
    input  logic         mac_mdc_o,
    output logic         mac_mdc_i,
    input  logic         mac_mdio_o,
    input  logic         mac_mdio_oe,
    output logic         mac_mdio_i,
    input  logic         ind_mdc,
    input  logic         ind_mdio,
    input  logic [W-1:0] mfp_in,
    output logic [W-1:0] mfp_out,
    output logic [W-1:0] mfp_oe,
    input  logic         mdc_pad_in,
    output logic         mdc_pad_out,
    output logic         mdc_pad_oe,
    input  logic         mdio_pad_in,
    output logic         mdio_pad_out,
    output logic         mdio_pad_oe,
    output logic [1:0]   mode_status
);
    pin_mode_e    mode;
    logic         live;
    logic [W-1:0] dir;
    logic [W-1:0] dat;

    pm_strap_latch u_strap (
        .clk(clk), .rst_n(rst_n),
        .strap_sel_gpio(strap_sel_gpio), .strap_mac_side(strap_mac_side),
        .mode_q(mode), .live_q(live)
    );

    pm_gpio_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_dir(gpio_we_dir), .we_dat(gpio_we_dat), .wdata(gpio_wdata),
        .dir_q(dir), .dat_q(dat)
    );

    pm_pad_route #(.W(W)) u_route (
        .clk(clk), .rst_n(rst_n), .mode(mode), .live(live),
        .dir(dir), .dat(dat),
        .ref_clk_drive(ref_clk_drive), .ref_clk_gen(ref_clk_gen),
        .mac_tx_en(mac_tx_en), .mac_txd(mac_txd),
        .mac_crs_dv(mac_crs_dv), .mac_rxd(mac_rxd), .mac_ref_clk(mac_ref_clk),
        .mac_mdc_o(mac_mdc_o), .mac_mdc_i(mac_mdc_i),
        .mac_mdio_o(mac_mdio_o), .mac_mdio_oe(mac_mdio_oe), .mac_mdio_i(mac_mdio_i),
        .ind_mdc(ind_mdc), .ind_mdio(ind_mdio),
        .mfp_in(mfp_in), .mfp_out(mfp_out), .mfp_oe(mfp_oe),
        .mdc_pad_in(mdc_pad_in), .mdc_pad_out(mdc_pad_out), .mdc_pad_oe(mdc_pad_oe),
        .mdio_pad_in(mdio_pad_in), .mdio_pad_out(mdio_pad_out), .mdio_pad_oe(mdio_pad_oe)
    );

    // Pad levels are readable in every mode.
    assign gpio_rdata  = mfp_in;
    assign mode_status = mode;

    AST_STATUS_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        mode_status != 2'b11); // R1
endmodule

// File: tb/sim_pinmux_rmii_top.sv
module sim_pinmux_rmii_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, sg = 1'b0, sm = 1'b0, rdrv = 1'b0, rgen = 1'b1;
    logic we_dir = 1'b0, we_dat = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic tx_en = 1'b0; logic [1:0] txd = '0;
    logic crs; logic [1:0] rxd; logic refc;
    logic mdc_o = 1'b1, mdc_i, mdio_o = 1'b1, mdio_oe = 1'b1, mdio_i;
    logic ind_c = 1'b1, ind_d = 1'b0;
    logic [7:0] pin_in = '0, pout, poe;
    logic mdc_in = 1'b0, mdc_out, mdc_oe, mdio_in = 1'b0, mdio_out, mdio_poe;
    logic [1:0] mst;

    pinmux_rmii_top u0 (
        .clk(clk), .rst_n(rst_n), .strap_sel_gpio(sg), .strap_mac_side(sm),
        .ref_clk_drive(rdrv), .ref_clk_gen(rgen),
        .gpio_we_dir(we_dir), .gpio_we_dat(we_dat), .gpio_wdata(wdata), .gpio_rdata(rdata),
        .mac_tx_en(tx_en), .mac_txd(txd), .mac_crs_dv(crs), .mac_rxd(rxd), .mac_ref_clk(refc),
        .mac_mdc_o(mdc_o), .mac_mdc_i(mdc_i), .mac_mdio_o(mdio_o), .mac_mdio_oe(mdio_oe),
        .mac_mdio_i(mdio_i), .ind_mdc(ind_c), .ind_mdio(ind_d),
        .mfp_in(pin_in), .mfp_out(pout), .mfp_oe(poe),
        .mdc_pad_in(mdc_in), .mdc_pad_out(mdc_out), .mdc_pad_oe(mdc_oe),
        .mdio_pad_in(mdio_in), .mdio_pad_out(mdio_out), .mdio_pad_oe(mdio_poe),
        .mode_status(mst)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Reset with given straps; returns at a negative edge with pads live.
    task automatic do_reset(input logic g, input logic m);
        @(negedge clk); rst_n = 1'b0; sg = g; sm = m;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // {strap[1:0], refdrv, pin_in, tx_en, txd, mode, oe, out, crs, rxd, mdc_oe}
    typedef struct packed {
        logic [1:0] strap; logic rd; logic [7:0] pin; logic te; logic [1:0] td;
        logic [1:0] mode; logic [7:0] oe; logic [7:0] out;
        logic crs; logic [1:0] rxd; logic mdcoe;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b01, 1'b1, 8'b1100_0010, 1'b1, 2'b10, 2'b01, 8'b0011_1100, 8'b0010_1100, 1'b1, 2'b11, 1'b1},
        '{2'b01, 1'b0, 8'b0100_0000, 1'b0, 2'b01, 2'b01, 8'b0001_1100, 8'b0001_0000, 1'b0, 2'b10, 1'b1},
        '{2'b00, 1'b1, 8'b1000_0010, 1'b1, 2'b11, 2'b00, 8'b0011_1100, 8'b0011_1100, 1'b1, 2'b01, 1'b0},
        '{2'b00, 1'b0, 8'b0000_0000, 1'b0, 2'b10, 2'b00, 8'b0001_1100, 8'b0000_1000, 1'b0, 2'b00, 1'b0},
        '{2'b10, 1'b1, 8'b1100_0010, 1'b1, 2'b11, 2'b10, 8'b0000_0000, 8'b0000_0000, 1'b0, 2'b00, 1'b1},
        '{2'b11, 1'b0, 8'b1111_1111, 1'b0, 2'b00, 2'b10, 8'b0000_0000, 8'b0000_0000, 1'b0, 2'b00, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        // Reset state (R2) and strap capture visible during reset (R1)
        sg = 1'b0; sm = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 oe in reset", {poe, mdc_oe, mdio_poe}, 0);
        chk("R1 status in reset", mst, 2'b01);

        // Vector walk: R1 R5 R6 R8 R9 R11 R3
        for (int i = 0; i < 6; i++) begin
            rdrv = VECS[i].rd;
            do_reset(VECS[i].strap[1], VECS[i].strap[0]);
            pin_in = VECS[i].pin; tx_en = VECS[i].te; txd = VECS[i].td;
            #1;
            chk("R1 mode", mst, VECS[i].mode);
            chk("R5/R6 oe", poe, VECS[i].oe);
            chk("R5/R6/R8 out", pout & poe, VECS[i].out);
            chk("R5/R6/R11 crs", crs, VECS[i].crs);
            chk("R5/R6/R11 rxd", rxd, VECS[i].rxd);
            chk("R9/R11 mdc oe", mdc_oe, VECS[i].mdcoe);
            chk("R3 rdata", rdata, VECS[i].pin);
        end

        // R8 refclk source
        rdrv = 1'b0; do_reset(1'b0, 1'b1);
        pin_in = 8'h20; rgen = 1'b0; #1;
        chk("R8 ref in from pad", refc, 1'b1);
        rdrv = 1'b1; #1;
        chk("R8 ref from gen", refc, 1'b0);
        rgen = 1'b1;

        // R10 mdio in MAC mode, R9 mdc out
        mdio_oe = 1'b0; mdio_in = 1'b0; mdc_o = 1'b0; #1;
        chk("R10 mdio oe", mdio_poe, 1'b0);
        chk("R10 mdio in", mdio_i, 1'b0);
        chk("R9 mdc out", {mdc_oe, mdc_out}, 2'b10);
        chk("R9 mdc_i idle in MAC", mdc_i, 1'b0);
        mdio_oe = 1'b1; mdio_o = 1'b0; #1;
        chk("R10 mdio drive", {mdio_poe, mdio_out}, 2'b10);

        // R7: pad0 GPIO in MAC mode; RMII-owned bits ignored
        @(negedge clk); wdata = 8'hFF; we_dir = 1'b1; we_dat = 1'b1;
        tx_en = 1'b0; txd = 2'b00;
        @(negedge clk); we_dir = 1'b0; we_dat = 1'b0; #1;
        chk("R7 pad0 gpio", {poe[0], pout[0]}, 2'b11);
        chk("R7 rmii pads unaffected oe", poe[7:1], 7'b0011110);
        chk("R7 rmii pads unaffected out", pout[4:2], 3'b000);

        // R1: strap change after release ignored
        sg = 1'b1; sm = 1'b0;
        repeat (3) @(negedge clk); #1;
        chk("R1 straps ignored after release", mst, 2'b01);
        chk("R1 pads keep mode", poe[4:2], 3'b111);

        // R9 reverse: mdc input path
        do_reset(1'b0, 1'b0);
        mdc_in = 1'b1; #1;
        chk("R9 rev mdc in", {mdc_oe, mdc_i}, 2'b01);

        // R3/R4/R11 GPIO mode registers and indicators
        do_reset(1'b1, 1'b0);
        chk("R4 regs clear after reset", poe, 8'h00);
        chk("R11 indicators", {mdc_oe, mdc_out, mdio_poe, mdio_out}, 4'b1110);
        chk("R11 mdio idle", mdio_i, 1'b1);
        @(negedge clk); wdata = 8'hA5; we_dir = 1'b1;
        @(negedge clk); we_dir = 1'b0; wdata = 8'h3C; we_dat = 1'b1;
        @(negedge clk); we_dat = 1'b0; #1;
        chk("R3/R4 dir", poe, 8'hA5);
        chk("R3/R4 data", pout & poe, 8'h24);

        // Overlap: write lost in reset, write on release edge takes effect (R4, R2)
        @(negedge clk); rst_n = 1'b0; sg = 1'b1;
        wdata = 8'hFF; we_dir = 1'b1;
        @(negedge clk); #1;
        chk("R2 oe low in reset", poe, 8'h00);
        wdata = 8'h0F; rst_n = 1'b1;
        @(negedge clk); we_dir = 1'b0; #1;
        chk("R4 write on release edge", poe, 8'h0F);

        report();
    end
endmodule